// File: doc/BRIEF.md
# Random Byte Register Peripheral

This block is a small register-mapped peripheral that hands random bytes to software. It has three byte-wide registers in a 4 KiB window: a control/status register, a read-only data register and a mode register. A byte is produced only while the block is armed. Armed means that the enable bit is set and the mode register holds exactly the run code. Software polls control/status. When the block is armed and holds no byte, that poll loads a fresh byte and raises the valid flag. Software then reads the byte from the data register, and that read consumes it.

The entropy source is a free-running 16-bit linear feedback shift register. Its low byte is captured when a byte is loaded. Accesses take one cycle. Read data is registered and appears one clock after the read strobe. The side effects of a read take place on that same strobe edge.

Top module: `rand_byte_periph`

## Requirements
- R1: After reset, the control/status, data and mode registers are all 0x00, and `rdata` is 0x00.
- R2: Offset 0x000 selects control/status, 0x004 selects data and 0x008 selects mode. `rdata` is registered: it shows the read result in the cycle after `rd_en`, and it is 0x00 in any cycle that follows a cycle without `rd_en`.
- R3: The block is armed only when control/status bit 0 (enable) is 1 and the mode register equals exactly 0x02. Any other mode value, such as 0x82, 0x06 or 0x00, disarms it.
- R4: A read of control/status while the block is disarmed clears bit 1 (valid). The value returned already shows that bit cleared.
- R5: A read of control/status while the block is armed and valid is 0 loads the current LFSR low byte into the data register and sets valid. The value returned already shows valid set. If valid is already 1, the read reloads nothing.
- R6: A read of data while the block is armed and valid is 1 returns the held byte, clears valid and zeroes the held byte. Any other data read returns 0x00 and changes nothing.
- R7: A write to control/status takes bits 7:2 and bit 0 from `wdata` and keeps the current valid bit. Bits 5:2 are a prescaler field that is stored only.
- R8: Writes to the data offset are ignored. A write to mode stores the full byte, and a mode read returns the last byte written.
- R9: Reads of unmapped offsets return 0x00. Reads and writes of unmapped offsets have no side effects.
- R10: The LFSR resets to 0xACE1. Every clock it shifts left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. It never reaches zero.
- R11: When `rd_en` and `wr_en` are both high in the same cycle, the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
A valid flag that is set wrongly shows up at the next data read in two ways. A stale byte is returned where 0x00 was due, or 0x00 is returned where a byte was due. The next control/status read also shows the wrong bit 1. A held byte that is not cleared, or that is loaded at the wrong moment, shows as a mismatch against the LFSR value predicted for that exact cycle. It appears one clock after the read that exposes it. A wrong arming decision shows on the next poll, which fails to load a byte or loads one it should not.

// File: rtl/rand_byte_periph.sv
module rand_byte_periph #(
  parameter int ADDR_W = 12,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter logic [7:0] MODE_RUN = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam logic [ADDR_W-1:0] OFF_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_MODE = ADDR_W'(8);

  logic [7:0]  ctl_q, byte_q, mode_q, rdata_q;
  logic [15:0] lfsr_q;

  wire armed   = ctl_q[0] && (mode_q == MODE_RUN);
  wire hit_ctl = addr == OFF_CTL;
  wire hit_dat = addr == OFF_DATA;
  wire hit_mod = addr == OFF_MODE;
  wire rd_ctl  = rd_en && hit_ctl;
  wire rd_dat  = rd_en && hit_dat;
  wire rd_mod  = rd_en && hit_mod;
  wire wr_ok   = wr_en && !rd_en;
  wire lfsr_fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

  assign rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      byte_q  <= '0;
      mode_q  <= '0;
      rdata_q <= '0;
      lfsr_q  <= LFSR_SEED;
    end else begin
      lfsr_q  <= {lfsr_q[14:0], lfsr_fb};
      rdata_q <= '0;
      if (rd_ctl) begin
        if (!armed) begin
          ctl_q[1] <= 1'b0;
          rdata_q  <= {ctl_q[7:2], 1'b0, ctl_q[0]};
        end else if (!ctl_q[1]) begin
          byte_q   <= lfsr_q[7:0];
          ctl_q[1] <= 1'b1;
          rdata_q  <= {ctl_q[7:2], 1'b1, ctl_q[0]};
        end else begin
          rdata_q  <= ctl_q;
        end
      end
      if (rd_dat && armed && ctl_q[1]) begin
        rdata_q  <= byte_q;
        byte_q   <= '0;
        ctl_q[1] <= 1'b0;
      end
      if (rd_mod) rdata_q <= mode_q;
      if (wr_ok && hit_ctl) ctl_q <= {wdata[7:2], ctl_q[1], wdata[0]};
      if (wr_ok && hit_mod) mode_q <= wdata;
    end
  end

  // R4
  p_disarmed_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl && !armed |=> !ctl_q[1]);
  // R5
  p_valid_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[1]) |-> $past(rd_ctl && armed));
  p_load_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl && armed && !ctl_q[1] |=> byte_q == $past(lfsr_q[7:0]));
  // R6
  p_consume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dat && armed && ctl_q[1] |=> !ctl_q[1] && byte_q == 8'h00);
  // R7
  p_valid_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && hit_ctl |=> ctl_q[1] == $past(ctl_q[1]));
  // R9
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !hit_ctl && !hit_dat && !hit_mod |=> rdata == 8'h00);
  // R10
  p_lfsr_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0000);
endmodule

// File: tb/rand_byte_periph_tb.sv
module rand_byte_periph_tb;
  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int runs = 0, fails = 0;

  always #10 clk = ~clk;

  rand_byte_periph u_dut (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
                          .addr(addr), .wdata(wdata), .rdata(rdata));

  logic [15:0] m_lfsr;
  logic [7:0] m_ctl, m_byte, m_mode;
  logic pend = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always @(posedge clk) begin
    if (!rst_n) m_lfsr <= 16'hACE1;
    else m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    pend <= rd_en;
  end

  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      runs++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, rdata, e);
      end
    end
  end

  function automatic logic armed();
    return m_ctl[0] && m_mode == 8'h02;
  endfunction

  task automatic do_rd(input logic [11:0] a, input string t, input logic [7:0] wd = 0,
                       input logic also_wr = 0);
    logic [7:0] e;
    @(negedge clk);
    rd_en = 1; addr = a; wr_en = also_wr; wdata = wd;
    e = 0;
    if (a == 12'h000) begin
      if (!armed()) m_ctl[1] = 0;
      else if (!m_ctl[1]) begin m_byte = m_lfsr[7:0]; m_ctl[1] = 1; end
      e = m_ctl;
    end else if (a == 12'h004) begin
      if (armed() && m_ctl[1]) begin e = m_byte; m_byte = 0; m_ctl[1] = 0; end
    end else if (a == 12'h008) e = m_mode;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 0; wr_en = 0;
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    if (a == 12'h000) m_ctl = {d[7:2], m_ctl[1], d[0]};
    else if (a == 12'h008) m_mode = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    m_ctl = 0; m_byte = 0; m_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    runs++;
    if (rdata !== 8'h00) begin fails++; $display("FAIL R1: rdata=%02h expected=00", rdata); end
    do_rd(12'h000, "R1 ctl");
    do_rd(12'h008, "R1 mode");
    do_rd(12'h004, "R1 data");
    do_wr(12'h000, 8'h01);
    do_rd(12'h000, "R3 mode0 no load");
    do_rd(12'h004, "R3 data disarmed");
    do_wr(12'h008, 8'h82);
    do_rd(12'h000, "R3 mode82 no load");
    do_wr(12'h008, 8'h02);
    do_rd(12'h000, "R5 load");
    do_rd(12'h000, "R5 no reload");
    do_rd(12'h004, "R6 consume");
    do_rd(12'h004, "R6 empty read");
    do_rd(12'h000, "R5 second load");
    do_rd(12'h004, "R6 second byte");
    do_rd(12'h000, "R5 reload");
    do_wr(12'h000, 8'hFD);
    do_rd(12'h000, "R7 valid kept high");
    do_wr(12'h000, 8'h02);
    do_rd(12'h000, "R4 disarmed clears");
    do_wr(12'h000, 8'h03);
    do_rd(12'h004, "R7 valid not set by write");
    do_rd(12'h000, "R5 load again");
    do_wr(12'h008, 8'h06);
    do_rd(12'h004, "R3 mode06 data blocked");
    do_rd(12'h008, "R8 mode readback");
    do_wr(12'h008, 8'h02);
    do_wr(12'h004, 8'h55);
    do_wr(12'h00C, 8'hFF);
    do_rd(12'h00C, "R9 unmapped 0C");
    do_rd(12'hFFC, "R9 unmapped FFC");
    do_rd(12'h000, "R9 ctl unchanged");
    do_rd(12'h004, "R8 data write ignored");
    do_rd(12'h000, "R11 read wins", 8'h00, 1'b1);
    do_rd(12'h000, "R11 write dropped");
    do_rd(12'h004, "R10 lfsr byte");
    @(negedge clk);
    runs++;
    if (rdata !== 8'h00) begin fails++; $display("FAIL R2: idle rdata=%02h expected=00", rdata); end
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule